// File: doc/BRIEF.md
# Source-Routed Header Hop Decoder

This block holds the two ends of source routing in a 2-D mesh router. On the injecting side, a table keeps one complete path per destination node. Software loads the table through a write port before traffic starts. When a packet is launched towards a destination, the block reads that row and emits it as one or more routing flits. Each routing flit carries up to `HOPS_PER_FLIT` hop entries. A hop entry holds an output direction and the virtual channel that is statically assigned to the outgoing link of that hop.

On the transit side, a single-stage decoder looks at the routing flit at the head of an arriving packet. It drives the output direction and the next-hop VC request straight from the lowest entry, with no route calculation. It then rewrites the flit so that the next router finds its own entry in the lowest slot. When a flit has used up its last entry and more routing flits follow, the decoder flags that flit to be dropped. A flit whose count is already zero sends the packet to the local ejection port.

A row that is being turned into routing flits is locked: writes to it are refused until emission ends, so a route never changes in the middle of a packet.

Top module: `srhop_unit`

## Requirements
- R1: After reset `inj_busy`, `inj_valid` and `out_valid` are 0, and every table row holds a hop count of 0, so injecting to any destination yields one flit with last=1 and count=0.
- R2: An `inj_start` sampled while idle makes `inj_valid` high from the next cycle for exactly max(1, ceil(H/K)) consecutive cycles, one routing flit per cycle. H is the stored hop count and K is `HOPS_PER_FLIT`.
- R3: Routing flit layout: bit FW-1 is last, bits [K*EW +: CW] hold the entry count, and slot j is at [j*EW +: EW] with the direction in its two low bits and the VC above them. Direction codes are N=0, E=1, S=2, W=3. Flit i carries path hops i*K..i*K+K-1 in slot order, with count = min(K, H-i*K). Slots past the count are zero, and last is set only on the final flit.
- R4: `inj_start` is ignored while `inj_busy` is high.
- R5: A table write to the row currently being emitted is discarded. A write to any other row during emission takes effect.
- R6: A written hop count above `MAX_HOPS` is stored as `MAX_HOPS`.
- R7: A flit accepted with `in_valid` and a nonzero count gives, on the next cycle, `out_valid`=1, `out_port` = slot-0 direction and `out_vc` = slot-0 VC. `out_valid` is 0 in the cycle after one without `in_valid`.
- R8: For a nonzero count, `out_flit` holds the slots moved down by one (the top slot is zero), the count minus one, and the same last bit.
- R9: `out_drop` is 1 exactly when the input count was 1 and last was 0.
- R10: For an input count of 0, `out_port` = 4 (local), `out_vc` = 0, `out_drop` = 0, and `out_flit` equals the input flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table row write strobe |
| tbl_waddr | input | DW | Destination row to write |
| tbl_whops | input | HCW | Hop count of the written route |
| tbl_wpath | input | MAX_HOPS*EW | Hop entries, hop h at [h*EW +: EW] |
| inj_start | input | 1 | Launch routing flits for `inj_dest` |
| inj_dest | input | DW | Destination of the launched packet |
| inj_busy | output | 1 | Routing flits being emitted |
| inj_valid | output | 1 | `inj_flit` holds a routing flit |
| inj_flit | output | FW | Emitted routing flit |
| in_valid | input | 1 | Head routing flit present at the decoder |
| in_flit | input | FW | Head routing flit |
| out_valid | output | 1 | Decode result valid |
| out_port | output | 3 | Output direction, 4 = local ejection |
| out_vc | output | VCW | Next-hop virtual channel |
| out_drop | output | 1 | Flit fully consumed, discard it |
| out_flit | output | FW | Rewritten routing flit |

## Verification
The bench goes after routes whose length lands exactly on a flit boundary, is zero, or is saturated. An off-by-one count there would emit an extra flit, drop one, or put the last bit on the wrong flit. It overwrites the row being emitted and issues a second launch in mid-stream. A missing lock would splice two routes into one packet, and a missing busy guard would restart emission. On the decode side it feeds count-one flits with and without the last bit, and count-zero flits carrying stale slots. A wrong drop rule would either discard the final flit a later router needs, or keep spent flits in front of the next router's entry. Ejecting through a rewrite would corrupt the flit.

// File: rtl/srhop_pkg.sv
package srhop_pkg;

  localparam int DIR_W = 2;

  localparam logic [2:0] PORT_N     = 3'd0;
  localparam logic [2:0] PORT_E     = 3'd1;
  localparam logic [2:0] PORT_S     = 3'd2;
  localparam logic [2:0] PORT_W     = 3'd3;
  localparam logic [2:0] PORT_LOCAL = 3'd4;

  // number of routing flits for a route of the given length
  function automatic int route_flits(int hops, int per_flit);
    return (hops == 0) ? 1 : (hops + per_flit - 1) / per_flit;
  endfunction

  // entries carried by flit number idx of a route
  function automatic int flit_entries(int hops, int idx, int per_flit);
    int left;
    left = hops - idx * per_flit;
    if (left < 0) return 0;
    return (left > per_flit) ? per_flit : left;
  endfunction

  function automatic int sat_hops(int hops, int max_hops);
    return (hops > max_hops) ? max_hops : hops;
  endfunction

endpackage

// File: rtl/srhop_route_table.sv
module srhop_route_table #(
  parameter int N_DEST   = 16,
  parameter int MAX_HOPS = 8,
  parameter int EW       = 4,
  localparam int DW      = $clog2(N_DEST),
  localparam int HCW     = $clog2(MAX_HOPS + 1),
  localparam int PATH_W  = MAX_HOPS * EW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_addr,
  input  logic [HCW-1:0]    wr_hops,
  input  logic [PATH_W-1:0] wr_path,
  input  logic              lock_valid,
  input  logic [DW-1:0]     lock_addr,
  input  logic [DW-1:0]     rd_addr,
  output logic [HCW-1:0]    rd_hops,
  output logic [PATH_W-1:0] rd_path,
  output logic              lock_hit
);
  import srhop_pkg::*;

  logic [HCW-1:0]    hops_q [N_DEST];
  logic [PATH_W-1:0] path_q [N_DEST];
  logic [HCW-1:0]    hops_sat;

  assign hops_sat = HCW'(sat_hops(int'(wr_hops), MAX_HOPS));
  assign lock_hit = wr_en && lock_valid && (wr_addr == lock_addr);

  for (genvar g = 0; g < N_DEST; g++) begin : g_row
    logic row_we;
    assign row_we = wr_en && (wr_addr == DW'(g))
                    && !(lock_valid && (lock_addr == DW'(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hops_q[g] <= '0;
        path_q[g] <= '0;
      end else if (row_we) begin
        hops_q[g] <= hops_sat;
        path_q[g] <= wr_path;
      end
    end
  end

  assign rd_hops = hops_q[rd_addr];
  assign rd_path = path_q[rd_addr];

endmodule

// File: rtl/srhop_injector.sv
module srhop_injector #(
  parameter int N_DEST   = 16,
  parameter int MAX_HOPS = 8,
  parameter int K        = 4,
  parameter int EW       = 4,
  localparam int DW       = $clog2(N_DEST),
  localparam int HCW      = $clog2(MAX_HOPS + 1),
  localparam int PATH_W   = MAX_HOPS * EW,
  localparam int CW       = $clog2(K + 1),
  localparam int FW       = 1 + CW + K * EW,
  localparam int MAX_FL   = (MAX_HOPS + K - 1) / K,
  localparam int IW       = (MAX_FL > 1) ? $clog2(MAX_FL) : 1,
  localparam int PAD_W    = MAX_FL * K * EW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DW-1:0]     dest,
  input  logic [HCW-1:0]    row_hops,
  input  logic [PATH_W-1:0] row_path,
  output logic              busy,
  output logic [DW-1:0]     cur_dest,
  output logic              flit_valid,
  output logic [FW-1:0]     flit
);
  import srhop_pkg::*;

  logic          busy_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] dest_q;
  logic [PAD_W-1:0] pad_path;
  logic [K*EW-1:0]  slots;
  logic [CW-1:0]    cnt;
  logic             is_last;

  assign pad_path = PAD_W'(row_path);

  always_comb begin
    int base;
    int hops;
    base  = int'(idx_q) * K;
    hops  = int'(row_hops);
    slots = '0;
    for (int j = 0; j < K; j++) begin
      if (base + j < hops) slots[j*EW +: EW] = pad_path[(base + j)*EW +: EW];
    end
    cnt     = CW'(flit_entries(hops, int'(idx_q), K));
    is_last = (int'(idx_q) == route_flits(hops, K) - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      dest_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        dest_q <= dest;
      end
    end else if (is_last) begin
      busy_q <= 1'b0;
    end else begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign busy       = busy_q;
  assign cur_dest   = dest_q;
  assign flit_valid = busy_q;
  assign flit       = {is_last, cnt, slots};

endmodule

// File: rtl/srhop_hop_decoder.sv
module srhop_hop_decoder #(
  parameter int K   = 4,
  parameter int VCW = 2,
  localparam int EW = srhop_pkg::DIR_W + VCW,
  localparam int CW = $clog2(K + 1),
  localparam int FW = 1 + CW + K * EW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [FW-1:0]  in_flit,
  output logic           out_valid,
  output logic [2:0]     out_port,
  output logic [VCW-1:0] out_vc,
  output logic           out_drop,
  output logic [FW-1:0]  out_flit
);
  import srhop_pkg::*;

  logic            f_last;
  logic [CW-1:0]   f_cnt;
  logic [K*EW-1:0] f_slots;
  logic            take_hop;
  logic [2:0]      port_d;
  logic [VCW-1:0]  vc_d;
  logic            drop_d;
  logic [FW-1:0]   flit_d;

  assign f_last   = in_flit[FW-1];
  assign f_cnt    = in_flit[K*EW +: CW];
  assign f_slots  = in_flit[K*EW-1:0];
  assign take_hop = (f_cnt != '0);

  always_comb begin
    if (take_hop) begin
      port_d = {1'b0, f_slots[DIR_W-1:0]};
      vc_d   = f_slots[EW-1:DIR_W];
      drop_d = (f_cnt == CW'(1)) && !f_last;
      flit_d = {f_last, f_cnt - CW'(1), f_slots >> EW};
    end else begin
      port_d = PORT_LOCAL;
      vc_d   = '0;
      drop_d = 1'b0;
      flit_d = in_flit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_port  <= '0;
      out_vc    <= '0;
      out_drop  <= 1'b0;
      out_flit  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_port <= port_d;
        out_vc   <= vc_d;
        out_drop <= drop_d;
        out_flit <= flit_d;
      end
    end
  end

endmodule

// File: rtl/srhop_unit.sv
module srhop_unit #(
  parameter int N_DEST        = 16,
  parameter int VC_N          = 4,
  parameter int HOPS_PER_FLIT = 4,
  parameter int MAX_HOPS      = 8,
  localparam int DW     = $clog2(N_DEST),
  localparam int VCW    = $clog2(VC_N),
  localparam int EW     = srhop_pkg::DIR_W + VCW,
  localparam int HCW    = $clog2(MAX_HOPS + 1),
  localparam int PATH_W = MAX_HOPS * EW,
  localparam int CW     = $clog2(HOPS_PER_FLIT + 1),
  localparam int FW     = 1 + CW + HOPS_PER_FLIT * EW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [DW-1:0]     tbl_waddr,
  input  logic [HCW-1:0]    tbl_whops,
  input  logic [PATH_W-1:0] tbl_wpath,
  input  logic              inj_start,
  input  logic [DW-1:0]     inj_dest,
  output logic              inj_busy,
  output logic              inj_valid,
  output logic [FW-1:0]     inj_flit,
  input  logic              in_valid,
  input  logic [FW-1:0]     in_flit,
  output logic              out_valid,
  output logic [2:0]        out_port,
  output logic [VCW-1:0]    out_vc,
  output logic              out_drop,
  output logic [FW-1:0]     out_flit
);

  // named internal events for the checker
  logic              lock_hit;
  logic [DW-1:0]     cur_dest;
  logic [HCW-1:0]    cur_hops;
  logic [PATH_W-1:0] cur_path;

  srhop_route_table #(
    .N_DEST(N_DEST), .MAX_HOPS(MAX_HOPS), .EW(EW)
  ) table_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_addr(tbl_waddr), .wr_hops(tbl_whops), .wr_path(tbl_wpath),
    .lock_valid(inj_busy), .lock_addr(cur_dest),
    .rd_addr(cur_dest), .rd_hops(cur_hops), .rd_path(cur_path),
    .lock_hit(lock_hit)
  );

  srhop_injector #(
    .N_DEST(N_DEST), .MAX_HOPS(MAX_HOPS), .K(HOPS_PER_FLIT), .EW(EW)
  ) inj_i (
    .clk(clk), .rst_n(rst_n),
    .start(inj_start), .dest(inj_dest),
    .row_hops(cur_hops), .row_path(cur_path),
    .busy(inj_busy), .cur_dest(cur_dest),
    .flit_valid(inj_valid), .flit(inj_flit)
  );

  srhop_hop_decoder #(
    .K(HOPS_PER_FLIT), .VCW(VCW)
  ) dec_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_flit(in_flit),
    .out_valid(out_valid), .out_port(out_port), .out_vc(out_vc),
    .out_drop(out_drop), .out_flit(out_flit)
  );

endmodule

// File: rtl/srhop_unit_chk.sv
module srhop_unit_chk #(
  parameter int K      = 4,
  parameter int DW     = 4,
  parameter int HCW    = 4,
  parameter int PATH_W = 32,
  parameter int CW     = 3,
  parameter int FW     = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inj_busy,
  input logic              inj_valid,
  input logic [FW-1:0]     inj_flit,
  input logic              in_valid,
  input logic              out_valid,
  input logic [2:0]        out_port,
  input logic              out_drop,
  input logic [FW-1:0]     out_flit,
  input logic              lock_hit,
  input logic [DW-1:0]     cur_dest,
  input logic [HCW-1:0]    cur_hops,
  input logic [PATH_W-1:0] cur_path
);

  a_r7_accept_gives_result: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r7_idle_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r10_eject_never_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_port == 3'd4) |-> !out_drop);

  a_r9_drop_is_spent_nonlast: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_drop) |-> (!out_flit[FW-1] && out_flit[FW-2 -: CW] == '0));

  a_r5_locked_row_steady: assert property (@(posedge clk) disable iff (!rst_n)
    lock_hit |=> ($stable(cur_hops) && $stable(cur_path)));

  a_r4_dest_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    inj_busy |=> $stable(cur_dest));

  a_r2_last_closes_stream: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && inj_flit[FW-1]) |=> !inj_valid);

  a_r3_nonlast_is_full: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && !inj_flit[FW-1]) |-> (inj_flit[FW-2 -: CW] == CW'(K)));

endmodule

bind srhop_unit srhop_unit_chk #(
  .K(HOPS_PER_FLIT), .DW(DW), .HCW(HCW), .PATH_W(PATH_W), .CW(CW), .FW(FW)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .inj_busy(inj_busy), .inj_valid(inj_valid), .inj_flit(inj_flit),
  .in_valid(in_valid), .out_valid(out_valid), .out_port(out_port),
  .out_drop(out_drop), .out_flit(out_flit),
  .lock_hit(lock_hit), .cur_dest(cur_dest), .cur_hops(cur_hops), .cur_path(cur_path)
);

// File: tb/srhop_unit_tb_top.sv
`timescale 1ns/1ps
module srhop_unit_tb_top;

  localparam int FW = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [3:0]  tbl_waddr = '0;
  logic [3:0]  tbl_whops = '0;
  logic [31:0] tbl_wpath = '0;
  logic        inj_start = 1'b0;
  logic [3:0]  inj_dest = '0;
  logic        inj_busy, inj_valid;
  logic [FW-1:0] inj_flit;
  logic        in_valid = 1'b0;
  logic [FW-1:0] in_flit = '0;
  logic        out_valid;
  logic [2:0]  out_port;
  logic [1:0]  out_vc;
  logic        out_drop;
  logic [FW-1:0] out_flit;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [3:0]  mdl_hops [16];
  logic [31:0] mdl_path [16];

  always #2.5 clk = ~clk;

  srhop_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_whops(tbl_whops), .tbl_wpath(tbl_wpath),
    .inj_start(inj_start), .inj_dest(inj_dest),
    .inj_busy(inj_busy), .inj_valid(inj_valid), .inj_flit(inj_flit),
    .in_valid(in_valid), .in_flit(in_flit),
    .out_valid(out_valid), .out_port(out_port), .out_vc(out_vc),
    .out_drop(out_drop), .out_flit(out_flit)
  );

  // decode vectors: input {last,cnt,slots}, expected port/vc/drop and rewritten flit
  typedef struct packed {
    logic        i_last;
    logic [2:0]  i_cnt;
    logic [15:0] i_slots;
    logic [2:0]  e_port;
    logic [1:0]  e_vc;
    logic        e_drop;
    logic        e_last;
    logic [2:0]  e_cnt;
    logic [15:0] e_slots;
  } dvec_t;

  localparam int NV = 8;
  localparam dvec_t DVEC [NV] = '{
    '{1'b1, 3'd3, 16'h0961, 3'd1, 2'd0, 1'b0, 1'b1, 3'd2, 16'h0096},
    '{1'b0, 3'd4, 16'hF7B2, 3'd2, 2'd0, 1'b0, 1'b0, 3'd3, 16'h0F7B},
    '{1'b0, 3'd1, 16'h000D, 3'd1, 2'd3, 1'b1, 1'b0, 3'd0, 16'h0000},
    '{1'b1, 3'd1, 16'h0004, 3'd0, 2'd1, 1'b0, 1'b1, 3'd0, 16'h0000},
    '{1'b1, 3'd0, 16'h0000, 3'd4, 2'd0, 1'b0, 1'b1, 3'd0, 16'h0000},
    '{1'b1, 3'd0, 16'hABCD, 3'd4, 2'd0, 1'b0, 1'b1, 3'd0, 16'hABCD},
    '{1'b1, 3'd2, 16'h00EB, 3'd3, 2'd2, 1'b0, 1'b1, 3'd1, 16'h000E},
    '{1'b0, 3'd2, 16'h0038, 3'd0, 2'd2, 1'b0, 1'b0, 3'd1, 16'h0003}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected routing flit i of a route, built slot by slot
  function automatic logic [FW-1:0] exp_flit(input int hops, input logic [31:0] path, input int i);
    logic [15:0] s;
    int c;
    s = '0;
    for (int j = 0; j < 4; j++)
      if (i * 4 + j < hops) s[j*4 +: 4] = path[(i*4 + j)*4 +: 4];
    c = hops - i * 4;
    if (c > 4) c = 4;
    if (c < 0) c = 0;
    return {((i + 1) * 4 >= hops), 3'(c), s};
  endfunction

  task automatic tbl_write(input int d, input int h, input logic [31:0] p);
    tbl_we = 1'b1; tbl_waddr = 4'(d); tbl_whops = 4'(h); tbl_wpath = p;
    @(negedge clk);
    tbl_we = 1'b0;
    mdl_hops[d] = (h > 8) ? 4'd8 : 4'(h);
    mdl_path[d] = p;
  endtask

  task automatic inj_check(input int d, input string req);
    int h, nf;
    h  = int'(mdl_hops[d]);
    nf = (h == 0) ? 1 : (h + 3) / 4;
    inj_start = 1'b1; inj_dest = 4'(d);
    @(negedge clk);
    inj_start = 1'b0;
    for (int i = 0; i < nf; i++) begin
      check({req, " valid"}, 64'(inj_valid), 64'd1);
      check({req, " flit"}, 64'(inj_flit), 64'(exp_flit(h, mdl_path[d], i)));
      @(negedge clk);
    end
    check({req, " R2 stream end"}, 64'(inj_valid), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin mdl_hops[i] = '0; mdl_path[i] = '0; end
    repeat (3) @(negedge clk);
    check("R1 inj_busy", 64'(inj_busy), 64'd0);
    check("R1 inj_valid", 64'(inj_valid), 64'd0);
    check("R1 out_valid", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid idle", 64'(out_valid), 64'd0);
    inj_check(5, "R1 cleared row");

    // decoder vector walk
    for (int v = 0; v < NV; v++) begin
      in_valid = 1'b1;
      in_flit  = {DVEC[v].i_last, DVEC[v].i_cnt, DVEC[v].i_slots};
      @(negedge clk);
      check("R7 out_valid", 64'(out_valid), 64'd1);
      check("R7 R10 out_port", 64'(out_port), 64'(DVEC[v].e_port));
      check("R7 R10 out_vc", 64'(out_vc), 64'(DVEC[v].e_vc));
      check("R9 R10 out_drop", 64'(out_drop), 64'(DVEC[v].e_drop));
      check("R8 R10 out_flit", 64'(out_flit),
            64'({DVEC[v].e_last, DVEC[v].e_cnt, DVEC[v].e_slots}));
    end
    in_valid = 1'b0;
    @(negedge clk);
    check("R7 no input no result", 64'(out_valid), 64'd0);

    // injection lengths: two flits, exact boundary, maximum, zero, saturated
    tbl_write(3, 6, 32'h8765_4321);
    inj_check(3, "R2 R3 six hops");
    tbl_write(9, 4, 32'hFFFF_9C5A);
    inj_check(9, "R2 R3 four hops");
    tbl_write(12, 8, 32'h1357_9BDF);
    inj_check(12, "R2 R3 eight hops");
    tbl_write(2, 0, 32'hFFFF_FFFF);
    inj_check(2, "R2 R3 zero hops");
    tbl_write(14, 13, 32'h2468_ACE1);
    inj_check(14, "R6 saturated");

    // mid-stream: second launch and write to the locked row, then write to another row
    inj_start = 1'b1; inj_dest = 4'd3;
    @(negedge clk);
    check("R3 locked run flit0", 64'(inj_flit), 64'(exp_flit(6, 32'h8765_4321, 0)));
    inj_start = 1'b1; inj_dest = 4'd7;
    tbl_we = 1'b1; tbl_waddr = 4'd3; tbl_whops = 4'd1; tbl_wpath = 32'h0000_000F;
    @(negedge clk);
    check("R5 locked run flit1", 64'(inj_flit), 64'(exp_flit(6, 32'h8765_4321, 1)));
    tbl_waddr = 4'd7; tbl_whops = 4'd2; tbl_wpath = 32'h0000_00AB;
    mdl_hops[7] = 4'd2; mdl_path[7] = 32'h0000_00AB;
    @(negedge clk);
    tbl_we = 1'b0; inj_start = 1'b0;
    check("R4 launch while busy ignored", 64'(inj_valid), 64'd0);
    @(negedge clk);
    check("R4 still idle", 64'(inj_busy), 64'd0);
    inj_check(3, "R5 locked row kept");
    inj_check(7, "R5 other row written");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule